// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind a bit-level I2C receiver. The receiver reports START conditions (a repeated START arrives as a START), STOP conditions, every byte shifted in from the bus and every acknowledge slot. The block decides whether the slave drives an acknowledge for each received byte. It matches the start byte or bytes against a programmable device address in 7-bit or 10-bit form and recognises the general call. It keeps the slave-side status flags, raises a slave-request pulse and asks the transmit FIFO for a byte when a read transfer is accepted.

The start-acknowledge enable is a register bit that the block can clear by itself, so it is modelled here together with its software write port. The device address, the 10-bit mode, the general-call enable, the receive-acknowledge enable, the auto-clear enable and the FIFO-full flag are plain inputs. Every decision and every status flag is registered, so each appears one clock after the event that causes it.

Top module: `i2c_slv_addr_match`

## Requirements
- R1: With `addr10_en_i`=0, a first byte after START whose bits 7:1 equal `dev_addr_i[6:0]` is a match. Bits 9:7 of the address play no part. The byte is acknowledged only if `start_ack_en_o` is 1. `ack_vld_o` pulses and `ack_o` gives the decision one cycle after `byte_vld_i`.
- R2: With `addr10_en_i`=1, the header byte `11110`,`dev_addr_i[9:8]`,0 is acknowledged only if the start-acknowledge enable is 1. The next byte is matched against `dev_addr_i[7:0]`, with the same acknowledge rule. Acknowledging that second byte sets `addr10_acked_o`, which clears at every START.
- R3: After an acknowledged 10-bit write sequence, and with no STOP since, a header byte with direction bit 1 is a complete match on its own. Without such a sequence, that header is neither acknowledged nor counted as an access.
- R4: `acen_wr_i` loads `acen_wdata_i` into `start_ack_en_o`. If `autoclr_en_i`=1, the enable clears itself on the cycle after this slave acknowledges a complete start sequence. A software write in the same cycle takes priority over the auto-clear.
- R5: A first byte equal to 0x00 is a general call. It is acknowledged only if `gcall_en_i`=1. `gcall_acked_o` holds whether the latest first byte was an acknowledged general call.
- R6: After an acknowledged write sequence or general call, data bytes are acknowledged only if `rx_ack_en_i`=1 and `fifo_full_i`=0. Bytes arriving while the slave is not selected are never acknowledged.
- R7: `slave_access_o` sets on an address match whether or not it is acknowledged. It clears on START and on STOP.
- R8: `nwr_o` clears at START, then takes bit 0 of the first byte whether or not that byte is acknowledged. `nwr_acked_o` changes only when a start sequence or general call is acknowledged, and then takes its direction (0 for a general call).
- R9: `sreq_o` is a one-cycle pulse in the cycle in which `slave_access_o` is set by a match.
- R10: `fifo_pop_o` pulses once, together with the acknowledge, when a read start sequence is acknowledged.
- R11: `last_ack_o` takes the value of `ack_sda_low_i` at every `ack_slot_i`.
- R12: `bus_rst_i` clears `last_ack_o`, `nwr_o`, `nwr_acked_o`, `gcall_acked_o`, `slave_access_o` and `addr10_acked_o` in the next cycle. It leaves `start_ack_en_o` unchanged.
- R13: After `rst` every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | Reset of the bus-state flags |
| ev_start_i | input | 1 | START or repeated START seen |
| ev_stop_i | input | 1 | STOP seen |
| byte_vld_i | input | 1 | A received byte is present |
| byte_i | input | 8 | Received byte |
| ack_slot_i | input | 1 | An acknowledge slot took place on the bus |
| ack_sda_low_i | input | 1 | SDA was low in that slot |
| dev_addr_i | input | 10 | Own device address |
| addr10_en_i | input | 1 | 10-bit addressing |
| gcall_en_i | input | 1 | Acknowledge general calls |
| rx_ack_en_i | input | 1 | Acknowledge received data |
| fifo_full_i | input | 1 | Slave FIFO is full |
| autoclr_en_i | input | 1 | Start-acknowledge enable clears itself |
| acen_wr_i | input | 1 | Software write of the start-acknowledge enable |
| acen_wdata_i | input | 1 | Value written |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | Drive acknowledge |
| sreq_o | output | 1 | Slave-request pulse |
| fifo_pop_o | output | 1 | Pop one byte for transmission |
| start_ack_en_o | output | 1 | Start-acknowledge enable |
| slave_access_o | output | 1 | This slave was addressed |
| nwr_o | output | 1 | Direction of the latest start byte |
| nwr_acked_o | output | 1 | Direction of the last acknowledged start |
| gcall_acked_o | output | 1 | General call acknowledged |
| addr10_acked_o | output | 1 | 10-bit address acknowledged |
| last_ack_o | output | 1 | SDA low at the last acknowledge slot |

## Verification
The hardest state to reach is the one-byte 10-bit read. It needs an acknowledged two-byte write sequence, then a repeated START with the read header and no STOP in between. Random bytes almost never produce this. The stimulus therefore draws most bytes from the own 7-bit pattern, the 10-bit header with either direction, the lower address byte and 0x00. It keeps STOPs rare and sets the start-acknowledge enable often. Directed sequences cover the same path with and without the earlier write, and a bench model tracks the expected flags step by step.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int ADDR7_W = 7;
    localparam int HDR_W   = 5;
    localparam logic [HDR_W-1:0] HDR10 = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_RX,
        ST_SKIP
    } am_state_e;

    typedef struct packed {
        logic is_gcall;
        logic hit7;
        logic hdr10;
        logic lo10;
        logic dir;
    } addr_hit_t;

    typedef struct packed {
        logic ack;
        logic first;
        logic first_dir;
        logic gc_ack;
        logic access;
        logic seq_ack;
        logic dir_upd;
        logic dir_val;
        logic ten_ack;
        logic pop;
    } am_evt_t;

    function automatic logic f_hdr_hit(input logic [BYTE_W-1:0] b,
                                       input logic [ADDR_W-1:0] a);
        return (b[BYTE_W-1 -: HDR_W] == HDR10) &&
               (b[BYTE_W-HDR_W-1 -: 2] == a[ADDR_W-1 -: 2]);
    endfunction

endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] dev_addr,
    output addr_hit_t         hit
);
    always_comb begin
        hit.is_gcall = (rx_byte == '0);
        hit.hit7     = (rx_byte[BYTE_W-1:1] == dev_addr[ADDR7_W-1:0]);
        hit.hdr10    = f_hdr_hit(rx_byte, dev_addr);
        hit.lo10     = (rx_byte == dev_addr[BYTE_W-1:0]);
        hit.dir      = rx_byte[0];
    end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
    import i2c_am_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_rst,
    input  logic      ev_start,
    input  logic      ev_stop,
    input  logic      byte_vld,
    input  addr_hit_t hit,
    input  logic      addr10_en,
    input  logic      gcall_en,
    input  logic      rx_ack_en,
    input  logic      fifo_full,
    input  logic      acen,
    output am_evt_t   evt,
    output logic      ack_vld_o,
    output logic      ack_o,
    output logic      sreq_o,
    output logic      pop_o
);
    am_state_e state, nxt_state;
    logic      rem10, nxt_rem10;

    always_comb begin
        nxt_state = state;
        nxt_rem10 = rem10;
        evt       = '0;
        if (bus_rst) begin
            nxt_state = ST_IDLE;
            nxt_rem10 = 1'b0;
        end else if (ev_start) begin
            nxt_state = ST_ADDR;
        end else if (ev_stop) begin
            nxt_state = ST_IDLE;
            nxt_rem10 = 1'b0;
        end else if (byte_vld) begin
            unique case (state)
                ST_ADDR: begin
                    evt.first     = 1'b1;
                    evt.first_dir = hit.dir;
                    nxt_state     = ST_SKIP;
                    if (hit.is_gcall) begin
                        evt.gc_ack = gcall_en;
                        evt.ack    = gcall_en;
                        if (gcall_en) begin
                            evt.dir_upd = 1'b1;
                            evt.dir_val = 1'b0;
                            nxt_state   = ST_RX;
                        end
                    end else if (!addr10_en) begin
                        if (hit.hit7) begin
                            evt.access = 1'b1;
                            evt.ack    = acen;
                            if (acen) begin
                                evt.seq_ack = 1'b1;
                                evt.dir_upd = 1'b1;
                                evt.dir_val = hit.dir;
                                evt.pop     = hit.dir;
                                if (!hit.dir) nxt_state = ST_RX;
                            end
                        end
                    end else if (hit.hdr10 && !hit.dir) begin
                        evt.ack = acen;
                        if (acen) nxt_state = ST_ADDR2;
                    end else if (hit.hdr10 && rem10) begin
                        evt.access = 1'b1;
                        evt.ack    = acen;
                        if (acen) begin
                            evt.seq_ack = 1'b1;
                            evt.dir_upd = 1'b1;
                            evt.dir_val = 1'b1;
                            evt.ten_ack = 1'b1;
                            evt.pop     = 1'b1;
                        end
                    end
                end
                ST_ADDR2: begin
                    nxt_state = ST_SKIP;
                    if (hit.lo10) begin
                        evt.access = 1'b1;
                        evt.ack    = acen;
                        if (acen) begin
                            evt.seq_ack = 1'b1;
                            evt.dir_upd = 1'b1;
                            evt.dir_val = 1'b0;
                            evt.ten_ack = 1'b1;
                            nxt_rem10   = 1'b1;
                            nxt_state   = ST_RX;
                        end
                    end else begin
                        nxt_rem10 = 1'b0;
                    end
                end
                ST_RX:   evt.ack = rx_ack_en && !fifo_full;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rem10     <= 1'b0;
            ack_vld_o <= 1'b0;
            ack_o     <= 1'b0;
            sreq_o    <= 1'b0;
            pop_o     <= 1'b0;
        end else begin
            state     <= nxt_state;
            rem10     <= nxt_rem10;
            ack_vld_o <= byte_vld;
            ack_o     <= evt.ack;
            sreq_o    <= evt.access;
            pop_o     <= evt.pop;
        end
    end

    AST_SREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        sreq_o |=> !sreq_o); // R9
    AST_DATA_ACK_ROOM: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && state == ST_RX && !bus_rst && !ev_start && !ev_stop &&
         (fifo_full || !rx_ack_en)) |=> !ack_o); // R6
    AST_POP_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> (ack_o && ack_vld_o)); // R10
    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && (state == ST_IDLE || state == ST_SKIP) && !ev_start) |=> !ack_o); // R6

endmodule

// File: rtl/i2c_am_flags.sv
module i2c_am_flags
    import i2c_am_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_rst,
    input  logic    ev_start,
    input  logic    ev_stop,
    input  am_evt_t evt,
    input  logic    ack_slot,
    input  logic    ack_sda_low,
    input  logic    autoclr_en,
    input  logic    acen_wr,
    input  logic    acen_wdata,
    output logic    start_ack_en_o,
    output logic    slave_access_o,
    output logic    nwr_o,
    output logic    nwr_acked_o,
    output logic    gcall_acked_o,
    output logic    addr10_acked_o,
    output logic    last_ack_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_ack_en_o <= 1'b0;
            slave_access_o <= 1'b0;
            nwr_o          <= 1'b0;
            nwr_acked_o    <= 1'b0;
            gcall_acked_o  <= 1'b0;
            addr10_acked_o <= 1'b0;
            last_ack_o     <= 1'b0;
        end else begin
            if (acen_wr)
                start_ack_en_o <= acen_wdata;
            else if (evt.seq_ack && autoclr_en)
                start_ack_en_o <= 1'b0;

            if (bus_rst) begin
                slave_access_o <= 1'b0;
                nwr_o          <= 1'b0;
                nwr_acked_o    <= 1'b0;
                gcall_acked_o  <= 1'b0;
                addr10_acked_o <= 1'b0;
                last_ack_o     <= 1'b0;
            end else begin
                if (ack_slot) last_ack_o <= ack_sda_low;
                if (ev_start) begin
                    nwr_o          <= 1'b0;
                    slave_access_o <= 1'b0;
                    addr10_acked_o <= 1'b0;
                end else if (ev_stop) begin
                    slave_access_o <= 1'b0;
                end
                if (evt.first) begin
                    nwr_o         <= evt.first_dir;
                    gcall_acked_o <= evt.gc_ack;
                end
                if (evt.access)  slave_access_o <= 1'b1;
                if (evt.dir_upd) nwr_acked_o    <= evt.dir_val;
                if (evt.ten_ack) addr10_acked_o <= 1'b1;
            end
        end
    end

    AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> !(slave_access_o || nwr_o || nwr_acked_o || gcall_acked_o ||
                      addr10_acked_o || last_ack_o)); // R12
    AST_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
        (evt.seq_ack && autoclr_en && !acen_wr) |=> !start_ack_en_o); // R4
    AST_ACCESS_CLR: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_stop) |=> !slave_access_o); // R7
    AST_NWR_START: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !nwr_o); // R8

endmodule

// File: rtl/i2c_slv_addr_match.sv
module i2c_slv_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_i,
    input  logic              ev_start_i,
    input  logic              ev_stop_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ack_slot_i,
    input  logic              ack_sda_low_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              addr10_en_i,
    input  logic              gcall_en_i,
    input  logic              rx_ack_en_i,
    input  logic              fifo_full_i,
    input  logic              autoclr_en_i,
    input  logic              acen_wr_i,
    input  logic              acen_wdata_i,
    output logic              ack_vld_o,
    output logic              ack_o,
    output logic              sreq_o,
    output logic              fifo_pop_o,
    output logic              start_ack_en_o,
    output logic              slave_access_o,
    output logic              nwr_o,
    output logic              nwr_acked_o,
    output logic              gcall_acked_o,
    output logic              addr10_acked_o,
    output logic              last_ack_o
);
    addr_hit_t hit;
    am_evt_t   evt;

    i2c_am_decode u_dec (
        .rx_byte  (byte_i),
        .dev_addr (dev_addr_i),
        .hit      (hit)
    );

    i2c_am_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_rst   (bus_rst_i),
        .ev_start  (ev_start_i),
        .ev_stop   (ev_stop_i),
        .byte_vld  (byte_vld_i),
        .hit       (hit),
        .addr10_en (addr10_en_i),
        .gcall_en  (gcall_en_i),
        .rx_ack_en (rx_ack_en_i),
        .fifo_full (fifo_full_i),
        .acen      (start_ack_en_o),
        .evt       (evt),
        .ack_vld_o (ack_vld_o),
        .ack_o     (ack_o),
        .sreq_o    (sreq_o),
        .pop_o     (fifo_pop_o)
    );

    i2c_am_flags u_flags (
        .clk            (clk),
        .rst            (rst),
        .bus_rst        (bus_rst_i),
        .ev_start       (ev_start_i),
        .ev_stop        (ev_stop_i),
        .evt            (evt),
        .ack_slot       (ack_slot_i),
        .ack_sda_low    (ack_sda_low_i),
        .autoclr_en     (autoclr_en_i),
        .acen_wr        (acen_wr_i),
        .acen_wdata     (acen_wdata_i),
        .start_ack_en_o (start_ack_en_o),
        .slave_access_o (slave_access_o),
        .nwr_o          (nwr_o),
        .nwr_acked_o    (nwr_acked_o),
        .gcall_acked_o  (gcall_acked_o),
        .addr10_acked_o (addr10_acked_o),
        .last_ack_o     (last_ack_o)
    );

    AST_GCALL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(gcall_acked_o) |-> $past(gcall_en_i)); // R5
    AST_ACCESS_SREQ: assert property (@(posedge clk) disable iff (rst)
        sreq_o |-> slave_access_o); // R9

endmodule

// File: tb/i2c_slv_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_slv_addr_match_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic bus_rst_i = 0, ev_start_i = 0, ev_stop_i = 0, byte_vld_i = 0;
    logic [7:0] byte_i = '0;
    logic ack_slot_i = 0, ack_sda_low_i = 0;
    logic [9:0] c_dev = '0;
    logic c_a10 = 0, c_gc = 0, c_rx = 0, c_full = 0, c_auto = 0;
    logic acen_wr_i = 0, acen_wdata_i = 0;
    logic ack_vld_o, ack_o, sreq_o, fifo_pop_o, start_ack_en_o, slave_access_o;
    logic nwr_o, nwr_acked_o, gcall_acked_o, addr10_acked_o, last_ack_o;

    i2c_slv_addr_match dut_i (
        .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i), .ev_start_i(ev_start_i),
        .ev_stop_i(ev_stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .ack_slot_i(ack_slot_i), .ack_sda_low_i(ack_sda_low_i), .dev_addr_i(c_dev),
        .addr10_en_i(c_a10), .gcall_en_i(c_gc), .rx_ack_en_i(c_rx),
        .fifo_full_i(c_full), .autoclr_en_i(c_auto), .acen_wr_i(acen_wr_i),
        .acen_wdata_i(acen_wdata_i), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
        .sreq_o(sreq_o), .fifo_pop_o(fifo_pop_o), .start_ack_en_o(start_ack_en_o),
        .slave_access_o(slave_access_o), .nwr_o(nwr_o), .nwr_acked_o(nwr_acked_o),
        .gcall_acked_o(gcall_acked_o), .addr10_acked_o(addr10_acked_o),
        .last_ack_o(last_ack_o)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // bench model state: 0 idle, 1 first byte, 2 second byte, 3 receiving, 4 deselected
    int   m_st = 0;
    logic m_rem = 0, m_acen = 0, m_acc = 0, m_nwr = 0, m_nwra = 0;
    logic m_gca = 0, m_ten = 0, m_last = 0;

    function automatic logic [6:0] flag_vec();
        return {start_ack_en_o, slave_access_o, nwr_o, nwr_acked_o,
                gcall_acked_o, addr10_acked_o, last_ack_o};
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag, logic st, logic sp, logic bv, logic [7:0] b,
                        logic asl, logic sl, logic sw, logic sv, logic br);
        logic e_ack = 0, e_sreq = 0, e_pop = 0, seqa = 0, gc;
        if (br) begin
            m_st = 0; m_rem = 0; m_last = 0; m_nwr = 0; m_nwra = 0;
            m_gca = 0; m_acc = 0; m_ten = 0;
        end else begin
            if (asl) m_last = sl;
            if (st) begin
                m_st = 1; m_nwr = 0; m_acc = 0; m_ten = 0;
            end else if (sp) begin
                m_st = 0; m_rem = 0; m_acc = 0;
            end else if (bv) begin
                case (m_st)
                    1: begin
                        m_nwr = b[0];
                        gc = (b == 8'h00);
                        m_gca = gc && c_gc;
                        m_st = 4;
                        if (gc) begin
                            e_ack = c_gc;
                            if (c_gc) begin m_nwra = 0; m_st = 3; end
                        end else if (!c_a10) begin
                            if (b[7:1] == c_dev[6:0]) begin
                                m_acc = 1; e_sreq = 1; e_ack = m_acen;
                                if (m_acen) begin
                                    seqa = 1; m_nwra = b[0]; e_pop = b[0];
                                    if (!b[0]) m_st = 3;
                                end
                            end
                        end else if (b[7:1] == {5'b11110, c_dev[9:8]}) begin
                            if (!b[0]) begin
                                e_ack = m_acen;
                                if (m_acen) m_st = 2;
                            end else if (m_rem) begin
                                m_acc = 1; e_sreq = 1; e_ack = m_acen;
                                if (m_acen) begin
                                    seqa = 1; m_nwra = 1; m_ten = 1; e_pop = 1;
                                end
                            end
                        end
                    end
                    2: begin
                        m_st = 4;
                        if (b == c_dev[7:0]) begin
                            m_acc = 1; e_sreq = 1; e_ack = m_acen;
                            if (m_acen) begin
                                seqa = 1; m_nwra = 0; m_ten = 1; m_rem = 1; m_st = 3;
                            end
                        end else m_rem = 0;
                    end
                    3: e_ack = c_rx && !c_full;
                    default: ;
                endcase
            end
        end
        if (sw) m_acen = sv;
        else if (seqa && c_auto) m_acen = 0;

        ev_start_i = st; ev_stop_i = sp; byte_vld_i = bv; byte_i = b;
        ack_slot_i = asl; ack_sda_low_i = sl; acen_wr_i = sw; acen_wdata_i = sv;
        bus_rst_i = br;
        @(negedge clk);
        ev_start_i = 0; ev_stop_i = 0; byte_vld_i = 0; ack_slot_i = 0;
        acen_wr_i = 0; bus_rst_i = 0;
        check({tag, " ack/sreq/pop"}, {3'b0, ack_vld_o, ack_o, sreq_o, fifo_pop_o},
              {3'b0, bv, e_ack, e_sreq, e_pop});
        check({tag, " flags"}, flag_vec(),
              {m_acen, m_acc, m_nwr, m_nwra, m_gca, m_ten, m_last});
    endtask

    task automatic s_start(string t); step(t, 1, 0, 0, 8'h00, 0, 0, 0, 0, 0); endtask
    task automatic s_stop(string t);  step(t, 0, 1, 0, 8'h00, 0, 0, 0, 0, 0); endtask
    task automatic s_byte(string t, logic [7:0] b); step(t, 0, 0, 1, b, 0, 0, 0, 0, 0); endtask
    task automatic s_acen(string t, logic v); step(t, 0, 0, 0, 8'h00, 0, 0, 1, v, 0); endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R13 reset", flag_vec(), 7'b0);
        check("R13 reset outs", {3'b0, ack_vld_o, ack_o, sreq_o, fifo_pop_o}, 7'b0);

        // 7-bit write, upper bits of the address differ from the byte
        c_dev = 10'h3A5; c_rx = 1;
        s_acen("R4 sw write", 1);
        s_start("R7 start");
        s_byte("R1 7-bit match", 8'h4A);
        s_byte("R6 data ack", 8'h11);
        c_full = 1;
        s_byte("R6 fifo full", 8'h12);
        c_full = 0; c_rx = 0;
        s_byte("R6 rx disabled", 8'h13);
        c_rx = 1;
        s_stop("R7 stop clears");
        s_byte("R6 not selected", 8'h14);
        s_start("R7 start");
        s_byte("R1 mismatch", 8'h4C);

        // read with auto-clear, then an unacknowledged match
        c_auto = 1;
        s_start("R8 start");
        s_byte("R10 read pop", 8'h4B);
        s_start("R8 restart");
        s_byte("R7 access without ack", 8'h4A);
        s_stop("R7 stop");

        // general call
        s_start("R5 start");
        s_byte("R5 gcall disabled", 8'h00);
        c_gc = 1;
        s_start("R5 start");
        s_byte("R5 gcall acked", 8'h00);
        s_byte("R6 data after gcall", 8'h5A);
        s_start("R5 start");
        s_byte("R5 gcall flag drops", 8'h4A);
        s_stop("R5 stop");

        // 10-bit addressing
        c_a10 = 1; c_auto = 0; c_dev = 10'h2C7;
        s_acen("R4 sw write", 1);
        s_start("R3 read before write");
        s_byte("R3 header read, no history", 8'hF5);
        s_start("R2 start");
        s_byte("R2 header write", 8'hF4);
        s_byte("R2 low byte", 8'hC7);
        s_byte("R6 10-bit data", 8'h99);
        s_start("R3 repeated start");
        s_byte("R3 one-byte read", 8'hF5);
        s_stop("R3 stop");
        s_start("R3 start after stop");
        s_byte("R3 read refused", 8'hF5);
        s_start("R2 start");
        s_byte("R2 header", 8'hF4);
        s_byte("R2 low mismatch", 8'hC6);

        // auto-clear versus same-cycle write
        c_a10 = 0; c_auto = 1; c_dev = 10'h025;
        s_start("R4 start");
        step("R4 write wins", 0, 0, 1, 8'h4A, 0, 0, 1, 1, 0);

        // acknowledge slots and bus reset
        step("R11 ack low", 0, 0, 0, 8'h00, 1, 1, 0, 0, 0);
        step("R11 ack high", 0, 0, 0, 8'h00, 1, 0, 0, 0, 0);
        step("R11 ack low", 0, 0, 0, 8'h00, 1, 1, 0, 0, 0);
        s_start("R12 start");
        s_byte("R12 read", 8'h4B);
        step("R12 bus reset", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int k = $urandom_range(0, 99);
            if (k < 12) s_start("R7 rnd start");
            else if (k < 16) s_stop("R7 rnd stop");
            else if (k < 78) begin
                logic [7:0] b;
                int sel = $urandom_range(0, 5);
                logic d = 1'($urandom_range(0, 1));
                case (sel)
                    0: b = {c_dev[6:0], d};
                    1: b = {5'b11110, c_dev[9:8], d};
                    2: b = c_dev[7:0];
                    3: b = 8'h00;
                    default: b = 8'($urandom);
                endcase
                s_byte("R1 rnd byte", b);
            end else if (k < 84)
                step("R11 rnd slot", 0, 0, 0, 8'h00, 1, 1'($urandom_range(0, 1)), 0, 0, 0);
            else if (k < 92) s_acen("R4 rnd write", $urandom_range(0, 9) < 8);
            else if (k < 93) step("R12 rnd reset", 0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
            else begin
                c_gc = 1'($urandom_range(0, 1));
                c_rx = $urandom_range(0, 3) != 0;
                c_full = $urandom_range(0, 3) == 0;
                c_auto = 1'($urandom_range(0, 1));
                if ($urandom_range(0, 7) == 0) begin
                    c_a10 = 1'($urandom_range(0, 1));
                    c_dev = 10'($urandom);
                end
                step("R6 rnd cfg", 0, 0, 0, 8'h00, 0, 0, 0, 0, 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule